// File: doc/BRIEF.md
# Recirculating Sample History Buffer

This block keeps the most recent input samples of a multi-tap filter that owns a single multiply-accumulate unit. The buffer holds one word per tap. During one filter computation the controller steps through the buffer with an advance strobe, and the buffer presents each stored sample exactly once. The newest sample comes first and the oldest comes last, so the sample shown at step k pairs with coefficient k.

When a pass is complete the read pointer rests on the newest word again. At that point a load strobe accepts a fresh input sample. The sample overwrites the oldest word and becomes the new newest word. A load that arrives while a pass is under way is dropped. Reset clears every stored word to zero, so no leftover sample can reach the filter output.

Top module: `hist_ring`

## Requirements
- R1: While reset is asserted, and afterwards until the first accepted load, every stored word reads as zero. Reset drives `word_o` to zero and `newest_o` high.
- R2: `word_o` always shows the word under the read pointer. Each advance without a load moves the pointer to the next older sample, and `word_o` shows that sample in the following cycle.
- R3: A pass of exactly DEPTH advances from the newest position shows the samples newest to oldest. `newest_o` stays low after advances 1 through DEPTH-1 and is high again after advance DEPTH.
- R4: A load without an advance while `newest_o` is high stores `sample_i` as the newest word. In the next cycle `word_o` equals that sample and `newest_o` stays high.
- R5: A load while `newest_o` is low has no effect. `word_o` keeps the word of the current step, and the stored history is unchanged in the rest of the pass and in the next pass.
- R6: A load and an advance in the same cycle while `newest_o` is high act as a load followed by one advance. In the next cycle `newest_o` is low and `word_o` shows the previously newest sample. The rest of the pass continues from step 1.
- R7: The buffer holds the last DEPTH accepted samples. Each accepted load discards the oldest one, so a pass always shows accepted samples in reverse arrival order.
- R8: In a cycle with neither advance nor load, `word_o` and `newest_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Step the read pointer to the next older sample |
| load_i | input | 1 | Accept `sample_i`; honoured only while `newest_o` is high |
| sample_i | input | WIDTH | Incoming sample |
| word_o | output | WIDTH | Word under the read pointer |
| newest_o | output | 1 | High when the pointer rests on the newest word (no pass in progress) |

## Verification
The bench builds the buffer with DEPTH=4 and WIDTH=6. This is small enough to load every one of the 64 sample codes and to follow each load with a full pass. Every pointer position therefore takes part in many writes and wraps. The small depth also makes it cheap to test a dropped load at every step of a pass, a combined load and advance, and a reset during a pass, each against a reference history kept by shifting in the bench.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Operation applied to the ring in one cycle, after load acceptance.
  // Bit 1: accepted load, bit 0: advance.
  typedef enum logic [1:0] {
    OP_NONE      = 2'b00,
    OP_STEP      = 2'b01,
    OP_LOAD      = 2'b10,
    OP_LOAD_STEP = 2'b11
  } hist_op_e;

endpackage

// File: rtl/hist_ptr_ctrl.sv
module hist_ptr_ctrl
  import hist_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          load_i,
  output logic [PW-1:0] rd_ptr_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic          wr_en_o,
  output logic          at_newest_o
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] tap_q, tap_d;
  logic          load_ok;
  hist_op_e      op;

  // Older neighbour: one slot down, wrapping at zero.
  function automatic logic [PW-1:0] older(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - ONE;
  endfunction

  // Slot that receives the next load: one slot up, wrapping at the top.
  function automatic logic [PW-1:0] newer(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + ONE;
  endfunction

  assign load_ok = load_i && (tap_q == '0);

  always_comb begin
    op = hist_op_e'({load_ok, adv_i});
  end

  always_comb begin
    ptr_d = ptr_q;
    tap_d = tap_q;
    unique case (op)
      OP_NONE: begin
        ptr_d = ptr_q;
        tap_d = tap_q;
      end
      OP_STEP: begin
        ptr_d = older(ptr_q);
        tap_d = (tap_q == LAST) ? '0 : tap_q + ONE;
      end
      OP_LOAD: begin
        ptr_d = newer(ptr_q);
        tap_d = '0;
      end
      OP_LOAD_STEP: begin
        // write one slot up, then step back down onto the previous newest
        ptr_d = ptr_q;
        tap_d = ONE;
      end
      default: begin
        ptr_d = ptr_q;
        tap_d = tap_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      tap_q <= '0;
    end else if (adv_i || load_ok) begin
      ptr_q <= ptr_d;
      tap_q <= tap_d;
    end
  end

  assign rd_ptr_o    = ptr_q;
  assign wr_ptr_o    = newer(ptr_q);
  assign wr_en_o     = load_ok;
  assign at_newest_o = (tap_q == '0);

  // R3: the last step of a pass lands back on the newest word
  a_r3_pass_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && tap_q == LAST) |=> at_newest_o);

  // R2: a plain advance moves the pointer to the older neighbour
  a_r2_step_older: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (ptr_q == older($past(ptr_q))));

  // R5: a load during a pass leaves the pointer alone when not advancing
  a_r5_midpass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !adv_i && tap_q != '0) |=> $stable(ptr_q));

endmodule

// File: rtl/hist_store.sv
module hist_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we_i && (waddr_i == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (hit) begin
        word_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = word_q[raddr_i];

  // R4: a write lands in the addressed slot
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (word_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/hist_ring.sv
module hist_ring
  import hist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic [WIDTH-1:0] word_o,
  output logic             newest_o
);

  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;
  logic          wr_en;

  hist_ptr_ctrl #(
    .DEPTH (DEPTH)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv_i),
    .load_i      (load_i),
    .rd_ptr_o    (rd_ptr),
    .wr_ptr_o    (wr_ptr),
    .wr_en_o     (wr_en),
    .at_newest_o (newest_o)
  );

  hist_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (sample_i),
    .raddr_i (rd_ptr),
    .rdata_o (word_o)
  );

  // R8: idle cycles hold the outputs
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> ($stable(word_o) && $stable(newest_o)));

  // R4: an accepted load shows the new sample next cycle
  a_r4_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !adv_i && newest_o) |=> (newest_o && word_o == $past(sample_i)));

  // R5: a load during a pass changes nothing visible
  a_r5_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !adv_i && !newest_o) |=> ($stable(word_o) && !newest_o));

  // R6: combined load and advance leaves the previous newest on the output
  a_r6_load_then_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i && newest_o) |=> (!newest_o && word_o == $past(word_o)));

endmodule

// File: tb/hist_ring_tb_top.sv
module hist_ring_tb_top;

  localparam int D = 4;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         adv = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] smp = '0;
  logic [W-1:0] word;
  logic         newest;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int hist [D];   // hist[0] newest

  always #10 clk = ~clk;  // 50 MHz

  hist_ring #(.DEPTH(D), .WIDTH(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .load_i   (load),
    .sample_i (smp),
    .word_o   (word),
    .newest_o (newest)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; applies inputs over one rising edge
  task automatic cyc(input bit a, input bit l, input int s);
    adv = a; load = l; smp = W'(s);
    @(negedge clk);
    adv = 1'b0; load = 1'b0;
  endtask

  task automatic push(input int s);
    for (int i = D - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
  endtask

  task automatic clear_model();
    for (int i = 0; i < D; i++) hist[i] = 0;
  endtask

  // full pass from newest position, checking each step
  task automatic full_pass(input string req);
    chk({req, " tap0 word"}, int'(word), hist[0]);
    for (int k = 1; k <= D; k++) begin
      cyc(1'b1, 1'b0, 0);
      if (k < D) begin
        chk({req, " R2 step word"}, int'(word), hist[k]);
        chk({req, " R3 newest low mid-pass"}, int'(newest), 0);
      end else begin
        chk({req, " R3 newest after full pass"}, int'(newest), 1);
        chk({req, " R3 back at newest"}, int'(word), hist[0]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (2) @(negedge clk);
    chk("R1 reset word", int'(word), 0);
    chk("R1 reset newest", int'(newest), 1);
    rst_n = 1'b1;
    @(negedge clk);
    full_pass("R1 zero history");

    // R4 R7: sweep every sample code, full pass after each load
    for (int v = 0; v < (1 << W); v++) begin
      cyc(1'b0, 1'b1, v);
      push(v);
      chk("R4 loaded word", int'(word), v);
      chk("R4 newest stays high", int'(newest), 1);
      full_pass("R7 history");
    end

    // R5: dropped load at each step of a pass
    for (int s = 1; s < D; s++) begin
      for (int k = 0; k < s; k++) cyc(1'b1, 1'b0, 0);
      cyc(1'b0, 1'b1, 7 + s);
      chk("R5 word kept", int'(word), hist[s]);
      chk("R5 newest low", int'(newest), 0);
      for (int k = s; k < D; k++) cyc(1'b1, 1'b0, 0);
      chk("R5 pass ends at newest", int'(newest), 1);
      full_pass("R5 history intact");
    end

    // R6: joint load and advance
    cyc(1'b1, 1'b1, 33);
    push(33);
    chk("R6 newest low", int'(newest), 0);
    chk("R6 previous newest shown", int'(word), hist[1]);
    for (int k = 2; k <= D; k++) begin
      cyc(1'b1, 1'b0, 0);
      if (k < D) chk("R6 continued step", int'(word), hist[k]);
    end
    chk("R6 pass closes", int'(newest), 1);
    full_pass("R6 history");

    // R8: idle cycles at rest and mid-pass
    cyc(1'b0, 1'b0, 21);
    chk("R8 idle word at rest", int'(word), hist[0]);
    chk("R8 idle newest at rest", int'(newest), 1);
    cyc(1'b1, 1'b0, 0);
    cyc(1'b0, 1'b0, 9);
    cyc(1'b0, 1'b0, 9);
    chk("R8 idle word mid-pass", int'(word), hist[1]);
    chk("R8 idle newest mid-pass", int'(newest), 0);

    // R1: reset in the middle of a pass
    rst_n = 1'b0;
    #1;
    chk("R1 async clear word", int'(word), 0);
    chk("R1 async clear newest", int'(newest), 1);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    @(negedge clk);
    full_pass("R1 cleared history");
    cyc(1'b0, 1'b1, 5);
    push(5);
    full_pass("R7 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule